// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

This block watches sixteen input lines and turns edges on them into interrupt requests and event pulses. Line n can be connected to pin n of any one of several I/O ports. A per-line port index picks the port. Each line has its own rising-edge enable, falling-edge enable, interrupt mask and event mask. An edge on a line with the interrupt mask set raises a sticky pending flag. Software clears that flag by writing a one to it. An edge on a line with the event mask set gives a pulse one cycle wide on the event output. The event path does not touch the pending flag.

Software sets the block up through a plain 32-bit register port. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. No data streams through the block, so it has no valid/ready handshake. Every port pin passes through a two-flop synchronizer before the line multiplexers. A change of port index masks edge detection on that line for one cycle, so switching ports cannot fake an edge.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset all readable registers (word indices 0 to 8) read 0, and `irq_req` and `evt_pulse` are 0.
- R2: Register word indices are: 0 rising enables, 1 falling enables, 2 interrupt masks, 3 event masks, 4 pending, 5 to 8 port selects. Line n uses bit n in registers 0 to 4. Bits 31:16 read 0. Pending is not writable as data. Word indices 9 to 15 read 0.
- R3: Line n takes its port index from select register 5 + n/4, bits 4*(n mod 4)+3 down to 4*(n mod 4). Index p picks port p, which is bit p*16+n of `port_pins`. An index of 7 or more gives a constant low. Pins of unselected ports have no effect.
- R4: A 0-to-1 change is detected when the line's rising enable is set. A 1-to-0 change is detected when its falling enable is set. With both enables set, both changes are detected. With neither set, no change is detected.
- R5: A pin change driven before clock edge k is seen at the outputs after clock edge k+2. The path is two synchronizer flops and one output register.
- R6: A detected edge sets the line's pending bit only when its interrupt mask is 1. The bit then stays set until it is cleared.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If an edge is detected in the same cycle as the clear, the bit stays set.
- R8: `irq_req[n]` is 1 exactly when pending bit n and interrupt mask bit n are both 1. Clearing the mask hides the request but keeps the pending bit.
- R9: A detected edge on a line with the event mask set drives `evt_pulse[n]` high for exactly one cycle and does not set the pending bit.
- R10: On the cycle after a write changes a line's port index, edge detection on that line is suppressed. Switching from a low pin to a high pin therefore records nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| port_pins | input | 112 | Pins of all ports; port p pin n is bit p*16+n |
| irq_req | output | 16 | Per-line interrupt request |
| evt_pulse | output | 16 | Per-line one-cycle event pulse |

## Verification
The bench sweeps every line against every port index, 0 to 7. At each point it first toggles a decoy pin on a different port at the same pin position, then toggles the selected pin. This separates a correct multiplexer from one that picks the wrong port or the wrong field, and it shows that the out-of-range index stays silent. All four rising/falling enable combinations are driven with both pin directions, which tells the edge polarities apart. Three single-cycle cases are also probed:
- the output latency, cycle by cycle;
- a clear that lands in the same cycle as a new edge;
- a port switch from a low pin to a high pin, which tests the suppression window.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  // Register word indices on the configuration port.
  typedef enum logic [3:0] {
    IDX_RISE  = 4'd0,
    IDX_FALL  = 4'd1,
    IDX_IMASK = 4'd2,
    IDX_EMASK = 4'd3,
    IDX_PEND  = 4'd4,
    IDX_SEL0  = 4'd5
  } reg_idx_e;

  localparam int BUS_W         = 32;
  localparam int LINES_PER_SEL = 4;
endpackage

// File: rtl/edge_irq_sync.sv
module edge_irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [BUS_W-1:0]           wdata,
  output logic [BUS_W-1:0]           rdata,
  input  logic [NUM_LINES-1:0]       edge_hit,
  output logic [NUM_LINES-1:0]       rise_en,
  output logic [NUM_LINES-1:0]       fall_en,
  output logic [NUM_LINES-1:0]       imask,
  output logic [NUM_LINES-1:0]       emask,
  output logic [NUM_LINES-1:0]       pend,
  output logic [NUM_LINES*SEL_W-1:0] sel_flat,
  output logic [NUM_LINES-1:0]       sel_chg
);
  localparam int LPS = LINES_PER_SEL;

  logic [NUM_LINES-1:0] rise_q, fall_q, imask_q, emask_q, pend_q, chg_q;
  logic [SEL_W-1:0]     sel_q [NUM_LINES];
  logic [NUM_LINES-1:0] clr_mask;
  logic                 unused_hi;

  assign unused_hi = ^wdata[BUS_W-1:NUM_LINES];

  function automatic logic hit_idx(input logic [ADDR_W-1:0] a, input reg_idx_e r);
    return a == ADDR_W'(r);
  endfunction

  assign clr_mask = (wr_en && hit_idx(addr, IDX_PEND)) ? wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q  <= '0;
      fall_q  <= '0;
      imask_q <= '0;
      emask_q <= '0;
      pend_q  <= '0;
    end else begin
      if (wr_en && hit_idx(addr, IDX_RISE))  rise_q  <= wdata[NUM_LINES-1:0];
      if (wr_en && hit_idx(addr, IDX_FALL))  fall_q  <= wdata[NUM_LINES-1:0];
      if (wr_en && hit_idx(addr, IDX_IMASK)) imask_q <= wdata[NUM_LINES-1:0];
      if (wr_en && hit_idx(addr, IDX_EMASK)) emask_q <= wdata[NUM_LINES-1:0];
      // A new edge outranks a clear in the same cycle.
      pend_q <= (pend_q & ~clr_mask) | (edge_hit & imask_q);
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_sel
    localparam int REGN = int'(IDX_SEL0) + n / LPS;
    localparam int OFS  = SEL_W * (n % LPS);
    logic sel_wr;
    assign sel_wr = wr_en && (addr == ADDR_W'(REGN));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[n] <= '0;
        chg_q[n] <= 1'b0;
      end else begin
        chg_q[n] <= sel_wr && (wdata[OFS +: SEL_W] != sel_q[n]);
        if (sel_wr) sel_q[n] <= wdata[OFS +: SEL_W];
      end
    end

    assign sel_flat[n*SEL_W +: SEL_W] = sel_q[n];

    // R6: a pending bit only appears from an interrupt-unmasked edge
    assert_pend_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(pend_q[n]) && pend_q[n]) |-> ($past(imask_q[n]) && $past(edge_hit[n])));
    // R7: a pending bit survives every cycle without a clear
    assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pend_q[n]) && !$past(clr_mask[n])) |-> pend_q[n]);
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_W'(IDX_RISE):  rdata[NUM_LINES-1:0] = rise_q;
      ADDR_W'(IDX_FALL):  rdata[NUM_LINES-1:0] = fall_q;
      ADDR_W'(IDX_IMASK): rdata[NUM_LINES-1:0] = imask_q;
      ADDR_W'(IDX_EMASK): rdata[NUM_LINES-1:0] = emask_q;
      ADDR_W'(IDX_PEND):  rdata[NUM_LINES-1:0] = pend_q;
      default: begin
        for (int n = 0; n < NUM_LINES; n++) begin
          if (addr == ADDR_W'(int'(IDX_SEL0) + n / LPS))
            rdata[SEL_W*(n % LPS) +: SEL_W] = sel_q[n];
        end
      end
    endcase
  end

  assign rise_en = rise_q;
  assign fall_en = fall_q;
  assign imask   = imask_q;
  assign emask   = emask_q;
  assign pend    = pend_q;
  assign sel_chg = chg_q;
endmodule

// File: rtl/edge_irq_line.sv
module edge_irq_line #(
  parameter int NUM_PORTS = 7,
  parameter int SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] col,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 sel_chg,
  input  logic                 rise_en,
  input  logic                 fall_en,
  input  logic                 emask,
  output logic                 hit,
  output logic                 evt
);
  localparam int NSEL = 1 << SEL_W;

  logic [NSEL-1:0] col_ext;
  logic            cur, prev_q, evt_q;

  // Indices beyond the last port land on zero-filled bits.
  assign col_ext = NSEL'(col);
  assign cur     = col_ext[sel];

  assign hit = !sel_chg &&
               ((rise_en && cur && !prev_q) || (fall_en && !cur && prev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= cur;
      evt_q  <= hit && emask;
    end
  end

  assign evt = evt_q;

  // R9: event pulses only follow an event-unmasked cycle
  assert_evt_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(emask));
  // R10: nothing fires from the cycle a port switch is settling
  assert_sel_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_chg) |-> !evt_q);
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 7,
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [BUS_W-1:0]               bus_wdata,
  output logic [BUS_W-1:0]               bus_rdata,
  input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
  output logic [NUM_LINES-1:0]           irq_req,
  output logic [NUM_LINES-1:0]           evt_pulse
);
  localparam int PIN_W = NUM_PORTS * NUM_LINES;

  logic [PIN_W-1:0]           pins_s;
  logic [NUM_LINES-1:0]       edge_hit, rise_en, fall_en, imask, emask, pend, sel_chg;
  logic [NUM_LINES*SEL_W-1:0] sel_flat;

  edge_irq_sync #(.WIDTH(PIN_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (port_pins),
    .q     (pins_s)
  );

  edge_irq_regs #(
    .NUM_LINES (NUM_LINES),
    .SEL_W     (SEL_W),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .edge_hit (edge_hit),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .imask    (imask),
    .emask    (emask),
    .pend     (pend),
    .sel_flat (sel_flat),
    .sel_chg  (sel_chg)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [NUM_PORTS-1:0] col;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_col
      assign col[p] = pins_s[p*NUM_LINES + n];
    end

    edge_irq_line #(
      .NUM_PORTS (NUM_PORTS),
      .SEL_W     (SEL_W)
    ) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .col     (col),
      .sel     (sel_flat[n*SEL_W +: SEL_W]),
      .sel_chg (sel_chg[n]),
      .rise_en (rise_en[n]),
      .fall_en (fall_en[n]),
      .emask   (emask[n]),
      .hit     (edge_hit[n]),
      .evt     (evt_pulse[n])
    );
  end

  assign irq_req = pend & imask;
endmodule

// File: tb/tb_edge_irq_ctrl.sv
module tb_edge_irq_ctrl;
  localparam int NL = 16;
  localparam int NP = 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_wr;
  logic [3:0]        bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [NP*NL-1:0]  pins;
  logic [NL-1:0]     irq_req;
  logic [NL-1:0]     evt_pulse;

  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] selsh [4];
  logic [31:0] rv;

  always #5 clk = ~clk;

  edge_irq_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .port_pins (pins),
    .irq_req   (irq_req),
    .evt_pulse (evt_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a);
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic setpin(input int p, input int n, input logic v);
    @(negedge clk);
    pins[p*NL + n] = v;
  endtask

  task automatic setsel(input int n, input int p);
    selsh[n/4][4*(n%4) +: 4] = 4'(p);
    wr(5 + n/4, selsh[n/4]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pins = '0;
    for (int i = 0; i < 4; i++) selsh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1: reset state
    for (int a = 0; a < 9; a++) begin
      rd(a, rv); chk("R1 reset register", rv, 32'h0);
    end
    chk("R1 reset irq", 32'(irq_req), 32'h0);
    chk("R1 reset evt", 32'(evt_pulse), 32'h0);

    // R2: register layout
    for (int a = 0; a < 9; a++) begin
      if (a != 4) begin
        wr(a, 32'hFFFF_FFFF); rd(a, rv);
        chk("R2 readback upper zero", rv, 32'h0000_FFFF);
        wr(a, 32'h0);
        rd(a, rv); chk("R2 cleared", rv, 32'h0);
      end
    end
    wr(4, 32'hFFFF_FFFF); rd(4, rv); chk("R2 pending not writable", rv, 32'h0);
    for (int a = 9; a < 16; a++) begin
      rd(a, rv); chk("R2 unused index", rv, 32'h0);
    end
    settle();

    // R3: every line against every port index, with a decoy port
    for (int n = 0; n < NL; n++) begin
      for (int p = 0; p < 8; p++) begin
        int q;
        q = (p + 1) % NP;
        setsel(n, p);
        wr(2, 32'(1) << n);
        wr(0, 32'(1) << n);
        settle();
        setpin(q, n, 1'b1);
        repeat (3) @(negedge clk);
        rd(4, rv); chk("R3 decoy port ignored", rv, 32'h0);
        if (p < NP) setpin(p, n, 1'b1);
        repeat (3) @(negedge clk);
        rd(4, rv); chk("R3 selected port", rv, (p < NP) ? (32'(1) << n) : 32'h0);
        pins = '0;
        settle();
        wr(4, 32'hFFFF);
        wr(0, 32'h0);
        wr(2, 32'h0);
        setsel(n, 0);
        settle();
      end
    end

    // R4: all enable combinations on line 5, port 0
    for (int m = 0; m < 4; m++) begin
      logic r, f;
      r = m[0]; f = m[1];
      wr(0, 32'(r) << 5);
      wr(1, 32'(f) << 5);
      wr(2, 32'(1) << 5);
      settle();
      setpin(0, 5, 1'b1);
      repeat (3) @(negedge clk);
      rd(4, rv); chk("R4 rising", rv, 32'(r) << 5);
      wr(4, 32'hFFFF);
      setpin(0, 5, 1'b0);
      repeat (3) @(negedge clk);
      rd(4, rv); chk("R4 falling", rv, 32'(f) << 5);
      wr(4, 32'hFFFF);
    end
    wr(0, 0); wr(1, 0); wr(2, 0);
    settle();

    // R5, R6, R9: event-only line 3, cycle-exact latency
    wr(3, 32'(1) << 3);
    wr(0, 32'(1) << 3);
    settle();
    setpin(0, 3, 1'b1);
    @(negedge clk); chk("R5 no pulse after 1 edge", 32'(evt_pulse), 32'h0);
    @(negedge clk); chk("R5 no pulse after 2 edges", 32'(evt_pulse), 32'h0);
    @(negedge clk); chk("R5 pulse after 3 edges", 32'(evt_pulse), 32'(1) << 3);
    @(negedge clk); chk("R9 pulse one cycle", 32'(evt_pulse), 32'h0);
    rd(4, rv); chk("R9 R6 no pending when masked", rv, 32'h0);
    chk("R6 no irq", 32'(irq_req), 32'h0);
    pins = '0;
    wr(0, 0); wr(3, 0);
    settle();

    // R7: write-1-to-clear, zero writes, set wins
    wr(0, 32'(1) << 2); wr(1, 32'(1) << 2); wr(2, 32'(1) << 2);
    settle();
    setpin(0, 2, 1'b1);
    repeat (3) @(negedge clk);
    rd(4, rv); chk("R7 pending set", rv, 32'(1) << 2);
    wr(4, 32'hFFFB); rd(4, rv); chk("R7 zero write no effect", rv, 32'(1) << 2);
    setpin(0, 2, 1'b0);
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd4; bus_wdata = 32'(1) << 2;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(4, rv); chk("R7 edge beats clear", rv, 32'(1) << 2);
    wr(4, 32'(1) << 2); rd(4, rv); chk("R7 clear works", rv, 32'h0);

    // R8: interrupt request gating
    setpin(0, 2, 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 irq with mask", 32'(irq_req), 32'(1) << 2);
    wr(2, 0);
    chk("R8 irq hidden", 32'(irq_req), 32'h0);
    rd(4, rv); chk("R8 pending kept", rv, 32'(1) << 2);
    wr(2, 32'(1) << 2);
    chk("R8 irq back", 32'(irq_req), 32'(1) << 2);
    wr(4, 32'hFFFF); wr(0, 0); wr(1, 0); wr(2, 0);
    pins = '0;
    settle();

    // R10: port switch from low to high pin must not record an edge
    setpin(1, 0, 1'b1);
    wr(0, 32'h1); wr(2, 32'h1);
    settle();
    wr(4, 32'hFFFF);
    setsel(0, 1);
    settle();
    rd(4, rv); chk("R10 no spurious edge", rv, 32'h0);
    setpin(1, 0, 1'b0);
    settle();
    setpin(1, 0, 1'b1);
    repeat (3) @(negedge clk);
    rd(4, rv); chk("R10 detection resumes", rv, 32'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule